// File: doc/BRIEF.md
# Pushbutton Lockout One-Shot Pulser

This block takes the raw level of a mechanical pushbutton and produces one clock-enable pulse, exactly one system clock wide, for each press. It fires on the first rising transition it sees. It then blanks every later transition for a counted lockout window, so contact bounce cannot produce a second pulse. A small counter inside the block uses that pulse as its enable, which shows that each press advances it by exactly one.

The raw level first passes through a two-flop synchronizer. It can optionally pass through a slow-tick sampling shift register after that. It then reaches a two-stage edge detector. The lockout window is armed by a press edge and also by a release edge, but only a press edge emits a pulse. As a result, bounce on release can never create a pulse either. The window length is a parameter. Its default is 480,000 cycles, which is 20 ms at 24 MHz and covers bounce lasting a few milliseconds with margin for switch ageing. An asynchronous active-low reset is released through a two-flop reset synchronizer.

Top module: `pb_oneshot_top`

## Requirements
- R1: While reset is asserted, press_pulse, lock_busy and press_count are all 0. The button is treated as released, so a button already held high when reset releases gives exactly one pulse and a count of 1.
- R2: With slow sampling off, a clean 0-to-1 change of btn_raw makes press_pulse high on the fourth rising clock edge after the change. It stays high for exactly one cycle.
- R3: A press made of a burst of bounce transitions that lasts less than the lockout window produces exactly one pulse. The count rises by exactly one.
- R4: lock_busy goes high on the same edge as a press pulse. It stays high for exactly LOCK_CYCLES cycles.
- R5: press_pulse never rises in a cycle that follows a cycle in which lock_busy was high.
- R6: A button held high after the lockout expires produces no further pulses.
- R7: A 1-to-0 change of the synchronized button level while idle starts a lockout window (lock_busy high) without a pulse. Release bounce inside that window produces no pulse.
- R8: press_count rises by one on the edge after each pulse, holds otherwise, and wraps from 2^COUNT_W-1 to 0.
- R9: After the lockout expires and the button has been released, a fresh 0-to-1 press produces a new pulse.
- R10: With SLOW_EN=1, the detector sees the button level only through a shift register that advances once every SLOW_DIV cycles. A bouncing press still yields exactly one pulse and one count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| btn_raw | input | 1 | Raw pushbutton level, 1 = pressed, asynchronous |
| press_pulse | output | 1 | One-cycle clock-enable pulse per press |
| lock_busy | output | 1 | High while a lockout window is running |
| press_count | output | COUNT_W | Demo counter advanced by press_pulse |

## Verification
A lockout counter that stops early or runs too long shows up as a lock_busy window of the wrong length. It also shows up as an extra count one edge after a bounce that should have been masked. A stuck or wrongly reset edge-detector stage gives no pulse, or a second pulse on a held button, within four cycles of the input change. A wrong gate between the edge and the lockout state shows at the ports as a release that pulses, or as press_count moving by more than one per press. The bench sees that move on the very next clock edge.

// File: rtl/pb_pkg.sv
package pb_pkg;

  // Lockout controller states: which edge armed the window
  typedef enum logic [1:0] {
    LK_IDLE    = 2'd0,
    LK_PRESS   = 2'd1,
    LK_RELEASE = 2'd2
  } lock_state_t;

  // Width helper that never returns zero
  function automatic int safe_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pb_reset_sync.sv
module pb_reset_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_out = stage_q[1];

endmodule

// File: rtl/pb_sync.sv
module pb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], d_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_n;
    end
  end

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/pb_slow_sample.sv
module pb_slow_sample #(
  parameter int DIV  = 24000,
  parameter int TAPS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  localparam int DIV_W = pb_pkg::safe_width(DIV);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] div_q, div_n;
  logic             tick;
  logic [TAPS-1:0]  samp_q, samp_n;

  always_comb begin
    tick  = (div_q == DIV_LAST);
    div_n = tick ? '0 : div_q + 1'b1;
  end

  always_comb begin
    samp_n = samp_q;
    if (tick) begin
      samp_n = {samp_q[TAPS-2:0], d_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      samp_q <= '0;
    end else begin
      div_q  <= div_n;
      samp_q <= samp_n;
    end
  end

  assign d_out = samp_q[TAPS-1];

  AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(samp_q)); // R10

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= DIV_LAST); // R10

endmodule

// File: rtl/pb_edge_lock.sv
module pb_edge_lock
  import pb_pkg::*;
#(
  parameter int LOCK_CYCLES = 480000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse,
  output logic busy
);

  localparam int LCNT_W = safe_width(LOCK_CYCLES);
  localparam logic [LCNT_W-1:0] LOCK_LAST = LCNT_W'(LOCK_CYCLES - 1);

  logic              lvl_new_q, lvl_old_q;
  logic              rise, fall;
  lock_state_t       state_q, state_n;
  logic [LCNT_W-1:0] lcnt_q, lcnt_n;
  logic              pulse_q, pulse_n;

  // Two-stage differentiator on the conditioned level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_new_q <= 1'b0;
      lvl_old_q <= 1'b0;
    end else begin
      lvl_new_q <= level;
      lvl_old_q <= lvl_new_q;
    end
  end

  assign rise = lvl_new_q & ~lvl_old_q;
  assign fall = ~lvl_new_q & lvl_old_q;

  // Lockout controller next state
  always_comb begin
    state_n = state_q;
    lcnt_n  = lcnt_q;
    pulse_n = 1'b0;
    unique case (state_q)
      LK_IDLE: begin
        if (rise) begin
          state_n = LK_PRESS;
          lcnt_n  = '0;
          pulse_n = 1'b1;
        end else if (fall) begin
          state_n = LK_RELEASE;
          lcnt_n  = '0;
        end
      end
      LK_PRESS, LK_RELEASE: begin
        if (lcnt_q == LOCK_LAST) begin
          state_n = LK_IDLE;
          lcnt_n  = '0;
        end else begin
          lcnt_n  = lcnt_q + 1'b1;
        end
      end
      default: begin
        state_n = LK_IDLE;
        lcnt_n  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_IDLE;
      lcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_n;
      lcnt_q  <= lcnt_n;
      pulse_q <= pulse_n;
    end
  end

  assign pulse = pulse_q;
  assign busy  = (state_q != LK_IDLE);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R2

  AST_PULSE_ARMS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (state_q == LK_PRESS)); // R4

  AST_NO_PULSE_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !pulse); // R5

  AST_LOCK_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (lcnt_q == '0)); // R4

  AST_LOCK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lcnt_q <= LOCK_LAST); // R4

  AST_RELEASE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_RELEASE) |-> !pulse); // R7

endmodule

// File: rtl/pb_demo_count.sv
module pb_demo_count #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (en) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign count = cnt_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (count == WIDTH'($past(count) + 1'b1))); // R8

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count)); // R8

endmodule

// File: rtl/pb_oneshot_top.sv
module pb_oneshot_top #(
  parameter int LOCK_CYCLES = 480000,
  parameter int COUNT_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit SLOW_EN     = 1'b0,
  parameter int SLOW_DIV    = 24000,
  parameter int SLOW_TAPS   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               btn_raw,
  output logic               press_pulse,
  output logic               lock_busy,
  output logic [COUNT_W-1:0] press_count
);

  logic rst_n_sync;
  logic btn_sync;
  logic btn_cond;
  logic pulse_w;

  pb_reset_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  pb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d_in  (btn_raw),
    .d_out (btn_sync)
  );

  generate
    if (SLOW_EN) begin : g_slow
      pb_slow_sample #(.DIV(SLOW_DIV), .TAPS(SLOW_TAPS)) u_slow (
        .clk   (clk),
        .rst_n (rst_n_sync),
        .d_in  (btn_sync),
        .d_out (btn_cond)
      );
    end else begin : g_direct
      assign btn_cond = btn_sync;
    end
  endgenerate

  pb_edge_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .level (btn_cond),
    .pulse (pulse_w),
    .busy  (lock_busy)
  );

  pb_demo_count #(.WIDTH(COUNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .en    (pulse_w),
    .count (press_count)
  );

  assign press_pulse = pulse_w;

endmodule

// File: tb/pb_oneshot_top_test.sv
module pb_oneshot_top_test;

  localparam int L  = 32;
  localparam int CW = 4;

  logic          clk;
  logic          rst_n;
  logic          btn;
  logic          btn_s;
  logic          pulse, busy, spulse, sbusy;
  logic [CW-1:0] count, scount;

  int checks = 0;
  int errors = 0;
  int npulse = 0;
  int nspulse = 0;
  int nviol = 0;
  logic busy_prev = 1'b0;

  pb_oneshot_top #(.LOCK_CYCLES(L), .COUNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn),
    .press_pulse(pulse), .lock_busy(busy), .press_count(count)
  );

  pb_oneshot_top #(.LOCK_CYCLES(L), .COUNT_W(CW), .SLOW_EN(1'b1),
                   .SLOW_DIV(4), .SLOW_TAPS(2)) uut_slow (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn_s),
    .press_pulse(spulse), .lock_busy(sbusy), .press_count(scount)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (pulse) npulse++;
    if (spulse) nspulse++;
    if (pulse && busy_prev) nviol++;
    busy_prev = busy;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a bouncing transition towards final level v on signal sel (0 main, 1 slow)
  task automatic bounce_to(input bit sel, input bit v, input int toggles);
    @(negedge clk);
    if (sel) btn_s = v; else btn = v;
    for (int i = 0; i < toggles * 2; i++) begin
      wait_cyc(1 + int'($urandom % 2));
      if (sel) btn_s = ~btn_s; else btn = ~btn;
    end
  endtask

  task automatic clean_cycle();
    @(negedge clk); btn = 1'b1;
    wait_cyc(L + 10);
    btn = 1'b0;
    wait_cyc(L + 10);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; btn = 1'b1; btn_s = 1'b0;
    wait_cyc(3);
    chk(pulse == 1'b0, "R1 pulse in reset", pulse, 0);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(count == '0, "R1 count in reset", count, 0);
    rst_n = 1'b1;
    wait_cyc(L + 12);
    chk(npulse == 1, "R1 held-through-reset pulses", npulse, 1);
    chk(count == 4'd1, "R1 held-through-reset count", count, 1);
    btn = 1'b0;
    wait_cyc(L + 12);
  endtask

  task automatic t_latency();
    int seen_busy;
    @(negedge clk); btn = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      chk(pulse == (i == 4), "R2 pulse latency/width", pulse, (i == 4));
      if (i == 4) begin
        chk(busy == 1'b1, "R4 busy with pulse", busy, 1);
        break;
      end
    end
    seen_busy = 1;
    @(negedge clk);
    while (busy && seen_busy < 4 * L) begin
      seen_busy++;
      @(negedge clk);
    end
    chk(seen_busy == L, "R4 busy length", seen_busy, L);
    wait_cyc(5);
    btn = 1'b0;
    wait_cyc(L + 10);
  endtask

  task automatic t_bounce();
    for (int p = 0; p < 5; p++) begin
      int p0 = npulse;
      logic [CW-1:0] c0 = count;
      bounce_to(1'b0, 1'b1, 3 + p % 3);
      wait_cyc(L + 10);
      bounce_to(1'b0, 1'b0, 3);
      wait_cyc(L + 10);
      chk(npulse - p0 == 1, "R3 pulses per bouncing press", npulse - p0, 1);
      chk(count == CW'(c0 + 1'b1), "R3 count per bouncing press", count, CW'(c0 + 1'b1));
    end
    chk(nviol == 0, "R5 pulse after busy cycle", nviol, 0);
  endtask

  task automatic t_held_release();
    int p0 = npulse;
    int rel_busy = 0;
    bounce_to(1'b0, 1'b1, 2);
    wait_cyc(3 * L);
    chk(npulse - p0 == 1, "R6 held button pulses", npulse - p0, 1);
    p0 = npulse;
    bounce_to(1'b0, 1'b0, 4);
    for (int i = 0; i < L + 10; i++) begin
      @(negedge clk);
      if (busy) rel_busy++;
    end
    chk(rel_busy > 0, "R7 release arms lockout", rel_busy, L);
    chk(npulse == p0, "R7 release pulses", npulse - p0, 0);
    p0 = npulse;
    clean_cycle();
    chk(npulse - p0 == 1, "R9 fresh press after lockout", npulse - p0, 1);
  endtask

  task automatic t_wrap();
    int steps = 16 - int'(count);
    for (int k = 0; k < steps; k++) begin
      logic [CW-1:0] c0 = count;
      clean_cycle();
      chk(count == CW'(c0 + 1'b1), "R8 count step", count, CW'(c0 + 1'b1));
    end
    chk(count == '0, "R8 count wrap", count, 0);
  endtask

  task automatic t_slow();
    int p0 = nspulse;
    logic [CW-1:0] c0 = scount;
    bounce_to(1'b1, 1'b1, 4);
    wait_cyc(6 * L);
    bounce_to(1'b1, 1'b0, 4);
    wait_cyc(6 * L);
    chk(nspulse - p0 == 1, "R10 slow path pulses", nspulse - p0, 1);
    chk(scount == CW'(c0 + 1'b1), "R10 slow path count", scount, CW'(c0 + 1'b1));
  endtask

  initial begin
    void'($urandom(7));
    t_reset();
    t_latency();
    t_bounce();
    t_held_release();
    t_wrap();
    t_slow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule